// File: doc/BRIEF.md
# Video Processor Serial Control Register Slave

This block is the serial-bus target that holds the control settings of a video processing chip. A host writes picture, drive, cut-off, geometry and switch settings over a two-wire serial bus (SCL and SDA), and the block presents every setting as a parallel output for the analog processing around it. SCL and SDA are sampled by a fast system clock. The block pulls SDA low through an open-drain enable to acknowledge a byte and to return read data.

A write carries the device address byte 0xBA, then a subaddress, then data. Bit 5 of the subaddress picks one of two modes. In single mode one register is written. In burst mode the register index moves forward after each data byte. A read with address byte 0xBB returns one status byte. That byte is built from the live status inputs and a sticky power-on flag, which clears once it has been read. The four picture-level settings (brightness, contrast, tint, saturation) are first held in shadow copies. They reach their outputs only on a vertical-blanking strobe, so a new value never takes effect in the middle of a field.

Top module: `vidctl_i2c_slave`

## Requirements
- R1: After reset the register outputs hold brightness 71, contrast 58, tint 64, saturation 72, sharpness 16, both drive settings 30, each cut-off 128, the five geometry settings 32 and the four control bytes 0, and sdaOe is 0.
- R2: The block acknowledges (sdaOe high during the ninth clock) the address byte 0xBA for writes and 0xBB for reads. It acknowledges no other address byte, and the bytes that follow such an address change no register.
- R3: A subaddress with bit 5 at 0 writes exactly one data byte into the register whose index is in subaddress bits 4:0. Further data bytes in the same transfer are acknowledged and discarded, and a register changes only when a data byte is written to it.
- R4: Each register keeps only its own width of a written byte. Indices 0x00–0x03 keep bits 6:0. Indices 0x04–0x06 and 0x0D–0x11 keep bits 5:0. Indices 0x07–0x0C and 0x12 keep all 8 bits.
- R5: A subaddress with bit 5 at 1 writes the data bytes to consecutive indices, starting at the index in bits 4:0.
- R6: In burst mode the index stops at 0x12. Any later data bytes in the same transfer overwrite register 0x12.
- R7: A subaddress whose index is above 0x12 is acknowledged, and its data bytes are acknowledged and discarded.
- R8: Writes to indices 0x00–0x03 change only the shadow copy. The output takes the shadow value in the cycle after a vblankStb pulse. A write that lands in the same cycle as the pulse appears only after the next pulse.
- R9: A read returns the status byte MSB first: bit 7 power-on flag, bit 6 field60, bit 5 lockLost, bit 4 stdIdent, bit 3 zero, bits 2:0 stdSel. The power-on flag is 1 on the first read after reset and 0 on every later read.
- R10: A start or stop condition seen in the middle of a byte drops that byte without writing it. A repeated start begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rstN | input | 1 | Asynchronous active-low reset (power-up) |
| sclIn | input | 1 | Serial bus clock line level |
| sdaIn | input | 1 | Serial bus data line level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| vblankStb | input | 1 | Single-cycle vertical-blanking strobe |
| lockLost | input | 1 | Line PLL not locked |
| field60 | input | 1 | 60 Hz field rate detected |
| stdIdent | input | 1 | Colour standard identified |
| stdSel | input | 3 | Detected colour standard code |
| brightOut | output | 7 | Brightness (index 0x00) |
| contrastOut | output | 7 | Contrast (index 0x01) |
| tintOut | output | 7 | Tint (index 0x02) |
| satOut | output | 7 | Saturation (index 0x03) |
| sharpOut | output | 6 | Sharpness (index 0x04) |
| rDriveOut | output | 6 | Red drive (index 0x05) |
| bDriveOut | output | 6 | Blue drive (index 0x06) |
| rCutOut | output | 8 | Red cut-off (index 0x07) |
| gCutOut | output | 8 | Green cut-off (index 0x08) |
| bCutOut | output | 8 | Blue cut-off (index 0x09) |
| srcCtrl | output | 8 | Source and standard control byte (index 0x0A) |
| lumaCtrl | output | 8 | Luma path control byte (index 0x0B) |
| filtCtrl | output | 8 | Filter and mode control byte (index 0x0C) |
| hShiftOut | output | 6 | Horizontal shift (index 0x0D) |
| vSlopeOut | output | 6 | Vertical slope (index 0x0E) |
| vSizeOut | output | 6 | Vertical size (index 0x0F) |
| sCorrOut | output | 6 | S-correction (index 0x10) |
| vShiftOut | output | 6 | Vertical shift (index 0x11) |
| deflCtrl | output | 8 | Deflection control byte (index 0x12) |

## Verification
The write path is tried in several ways: single writes across every register width, single writes with extra trailing bytes, bursts that start mid-file, and bursts that run into the last index. Together these separate correct index selection from off-by-one stepping, missing saturation and wrong masking. Writes to an index out of range and transfers to a foreign address show that discarded traffic leaves every output untouched. Two timings of a picture write against the blanking strobe show whether the shadow stage holds values back. Two reads with different status patterns show both the bit placement and the clearing of the power-on flag. Transfers cut short by a stop or by a repeated start show whether a partial byte can leak into a register.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

  localparam int NUM_REGS     = 19;
  localparam int IDX_W        = 5;
  localparam int SHADOW_REGS  = 4;
  localparam int AUTO_BIT     = 5;
  localparam int SYNC_STAGES  = 2;
  localparam logic [6:0] DEV_ADDR = 7'h5D;

  typedef struct packed {
    logic       subLoad;
    logic       dataWr;
    logic       rdLoad;
    logic [7:0] rxByte;
  } ctrlStb_t;

  function automatic logic [7:0] regMask(input int idx);
    if (idx <= 3)       return 8'h7F;
    else if (idx <= 6)  return 8'h3F;
    else if (idx <= 12) return 8'hFF;
    else if (idx <= 17) return 8'h3F;
    else                return 8'hFF;
  endfunction

  function automatic logic [7:0] regReset(input int idx);
    case (idx)
      0:                   return 8'd71;
      1:                   return 8'd58;
      2:                   return 8'd64;
      3:                   return 8'd72;
      4:                   return 8'd16;
      5, 6:                return 8'd30;
      7, 8, 9:             return 8'd128;
      13, 14, 15, 16, 17:  return 8'd32;
      default:             return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/vidctl_ctrl.sv
module vidctl_ctrl
  import vidctl_pkg::*;
#(
  parameter int         SYNC_N     = SYNC_STAGES,
  parameter logic [6:0] DEV_ADDR_P = DEV_ADDR
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] statusByte,
  output logic       sdaOe,
  output ctrlStb_t   stb
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} busState_t;

  logic [SYNC_N-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, txReg;
  logic [1:0] byteNum;
  logic       isRead, ackSeen;

  // two-flop synchronisers, idle bus is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_N-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_N-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_N-1];
  assign sdaS      = sdaSync[SYNC_N-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      txReg    <= '0;
      byteNum  <= '0;
      isRead   <= 1'b0;
      ackSeen  <= 1'b0;
      sdaOe    <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= '0;
      if (startCond) begin
        state   <= S_RX;
        bitCnt  <= '0;
        byteNum <= '0;
        isRead  <= 1'b0;
        sdaOe   <= 1'b0;
      end else if (stopCond) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              byteNum <= (byteNum == 2'd2) ? 2'd2 : byteNum + 2'd1;
              if (byteNum == 2'd0) begin
                if (shiftReg[7:1] == DEV_ADDR_P) begin
                  sdaOe      <= 1'b1;
                  isRead     <= shiftReg[0];
                  state      <= S_RXACK;
                  if (shiftReg[0]) begin
                    txReg      <= statusByte;
                    stb.rdLoad <= 1'b1;
                  end
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                sdaOe      <= 1'b1;
                state      <= S_RXACK;
                stb.rxByte <= shiftReg;
                if (byteNum == 2'd1) stb.subLoad <= 1'b1;
                else                 stb.dataWr  <= 1'b1;
              end
            end
          end
          S_RXACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                state <= S_TX;
                sdaOe <= ~txReg[7];
              end else begin
                state <= S_RX;
                sdaOe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                state <= S_TXACK;
                sdaOe <= 1'b0;
              end else begin
                txReg  <= {txReg[6:0], 1'b0};
                sdaOe  <= ~txReg[6];
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          S_TXACK: begin
            if (sclRise) begin
              ackSeen <= ~sdaS;
            end else if (sclFall) begin
              if (ackSeen) begin
                state      <= S_TX;
                bitCnt     <= '0;
                txReg      <= statusByte;
                sdaOe      <= ~statusByte[7];
                stb.rdLoad <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/vidctl_regs.sv
module vidctl_regs
  import vidctl_pkg::*;
#(
  parameter int NREG_P   = NUM_REGS,
  parameter int SHADOW_P = SHADOW_REGS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              vblankStb,
  input  logic              lockLost,
  input  logic              field60,
  input  logic              stdIdent,
  input  logic [2:0]        stdSel,
  output logic [7:0]        statusByte,
  output logic [NREG_P*8-1:0] regFlat
);

  localparam int LAST_IDX = NREG_P - 1;

  logic [IDX_W-1:0] wrIdx;
  logic             autoInc, singleDone, pod, wrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx      <= '0;
      autoInc    <= 1'b0;
      singleDone <= 1'b0;
      pod        <= 1'b1;
    end else begin
      if (stb.subLoad) begin
        wrIdx      <= stb.rxByte[IDX_W-1:0];
        autoInc    <= stb.rxByte[AUTO_BIT];
        singleDone <= 1'b0;
      end else if (stb.dataWr) begin
        if (!autoInc)                    singleDone <= 1'b1;
        else if (int'(wrIdx) < LAST_IDX) wrIdx <= wrIdx + 1'b1;
      end
      if (stb.rdLoad) pod <= 1'b0;
    end
  end

  assign wrEn       = stb.dataWr & ~singleDone;
  assign statusByte = {pod, field60, lockLost, stdIdent, 1'b0, stdSel};

  for (genvar g = 0; g < NREG_P; g++) begin : gReg
    logic [7:0] held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             held <= regReset(g);
      else if (wrEn && int'(wrIdx) == g)     held <= stb.rxByte & regMask(g);
    end
    if (g < SHADOW_P) begin : gShadow
      logic [7:0] live;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          live <= regReset(g);
        else if (vblankStb) live <= held;
      end
      assign regFlat[g*8 +: 8] = live;
    end else begin : gDirect
      assign regFlat[g*8 +: 8] = held;
    end
  end

endmodule

// File: rtl/vidctl_i2c_slave.sv
module vidctl_i2c_slave
  import vidctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       vblankStb,
  input  logic       lockLost,
  input  logic       field60,
  input  logic       stdIdent,
  input  logic [2:0] stdSel,
  output logic [6:0] brightOut,
  output logic [6:0] contrastOut,
  output logic [6:0] tintOut,
  output logic [6:0] satOut,
  output logic [5:0] sharpOut,
  output logic [5:0] rDriveOut,
  output logic [5:0] bDriveOut,
  output logic [7:0] rCutOut,
  output logic [7:0] gCutOut,
  output logic [7:0] bCutOut,
  output logic [7:0] srcCtrl,
  output logic [7:0] lumaCtrl,
  output logic [7:0] filtCtrl,
  output logic [5:0] hShiftOut,
  output logic [5:0] vSlopeOut,
  output logic [5:0] vSizeOut,
  output logic [5:0] sCorrOut,
  output logic [5:0] vShiftOut,
  output logic [7:0] deflCtrl
);

  ctrlStb_t               ctrlStb;
  logic [7:0]             statusByte;
  logic [NUM_REGS*8-1:0]  regFlat;
  logic                   unusedHi;

  vidctl_ctrl #(.SYNC_N(SYNC_STAGES), .DEV_ADDR_P(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .statusByte(statusByte), .sdaOe(sdaOe), .stb(ctrlStb)
  );

  vidctl_regs #(.NREG_P(NUM_REGS), .SHADOW_P(SHADOW_REGS)) uRegs (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .vblankStb(vblankStb),
    .lockLost(lockLost), .field60(field60), .stdIdent(stdIdent),
    .stdSel(stdSel), .statusByte(statusByte), .regFlat(regFlat)
  );

  assign brightOut   = regFlat[6:0];
  assign contrastOut = regFlat[14:8];
  assign tintOut     = regFlat[22:16];
  assign satOut      = regFlat[30:24];
  assign sharpOut    = regFlat[37:32];
  assign rDriveOut   = regFlat[45:40];
  assign bDriveOut   = regFlat[53:48];
  assign rCutOut     = regFlat[63:56];
  assign gCutOut     = regFlat[71:64];
  assign bCutOut     = regFlat[79:72];
  assign srcCtrl     = regFlat[87:80];
  assign lumaCtrl    = regFlat[95:88];
  assign filtCtrl    = regFlat[103:96];
  assign hShiftOut   = regFlat[109:104];
  assign vSlopeOut   = regFlat[117:112];
  assign vSizeOut    = regFlat[125:120];
  assign sCorrOut    = regFlat[133:128];
  assign vShiftOut   = regFlat[141:136];
  assign deflCtrl    = regFlat[151:144];

  // masked-off upper bits are always zero
  assign unusedHi = ^{regFlat[7], regFlat[15], regFlat[23], regFlat[31],
                      regFlat[39:38], regFlat[47:46], regFlat[55:54],
                      regFlat[111:110], regFlat[119:118], regFlat[127:126],
                      regFlat[135:134], regFlat[143:142]};

endmodule

// File: rtl/vidctl_chk.sv
module vidctl_chk
  import vidctl_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       vblankStb,
  input ctrlStb_t   stb,
  input logic [6:0] brightOut,
  input logic [6:0] satOut,
  input logic [5:0] rDriveOut,
  input logic [7:0] deflCtrl
);

  p_bright_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !vblankStb |=> $stable(brightOut));

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !vblankStb |=> $stable(satOut));

  p_direct_needs_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.dataWr |=> $stable(rDriveOut));

  p_last_needs_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.dataWr |=> $stable(deflCtrl));

  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.subLoad, stb.dataWr, stb.rdLoad}));

endmodule

bind vidctl_i2c_slave vidctl_chk uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .vblankStb(vblankStb), .stb(ctrlStb), .brightOut(brightOut),
  .satOut(satOut), .rDriveOut(rDriveOut), .deflCtrl(deflCtrl)
);

// File: tb/tb_vidctl_i2c_slave.sv
module tb_vidctl_i2c_slave;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 16;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 8;
  // {subaddress, data, expected register value}
  localparam logic [23:0] VECS [NVEC] = '{
    24'h05_3F_3F, 24'h04_FF_3F, 24'h07_A5_A5, 24'h0A_5A_5A,
    24'h12_81_81, 24'h0D_2A_2A, 24'h11_C7_07, 24'h09_00_00
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic vblankStb = 1'b0;
  logic lockLost = 1'b0, field60 = 1'b0, stdIdent = 1'b0;
  logic [2:0] stdSel = 3'b000;
  logic sdaOe, sdaLine;
  logic [6:0] brightOut, contrastOut, tintOut, satOut;
  logic [5:0] sharpOut, rDriveOut, bDriveOut, hShiftOut, vSlopeOut, vSizeOut, sCorrOut, vShiftOut;
  logic [7:0] rCutOut, gCutOut, bCutOut, srcCtrl, lumaCtrl, filtCtrl, deflCtrl;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;
  logic [7:0] model [19];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaOe;

  vidctl_i2c_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .vblankStb(vblankStb), .lockLost(lockLost), .field60(field60),
    .stdIdent(stdIdent), .stdSel(stdSel),
    .brightOut(brightOut), .contrastOut(contrastOut), .tintOut(tintOut), .satOut(satOut),
    .sharpOut(sharpOut), .rDriveOut(rDriveOut), .bDriveOut(bDriveOut),
    .rCutOut(rCutOut), .gCutOut(gCutOut), .bCutOut(bCutOut),
    .srcCtrl(srcCtrl), .lumaCtrl(lumaCtrl), .filtCtrl(filtCtrl),
    .hShiftOut(hShiftOut), .vSlopeOut(vSlopeOut), .vSizeOut(vSizeOut),
    .sCorrOut(sCorrOut), .vShiftOut(vShiftOut), .deflCtrl(deflCtrl)
  );

  function automatic logic [7:0] getOut(input int idx);
    case (idx)
      0: return {1'b0, brightOut};   1: return {1'b0, contrastOut};
      2: return {1'b0, tintOut};     3: return {1'b0, satOut};
      4: return {2'b0, sharpOut};    5: return {2'b0, rDriveOut};
      6: return {2'b0, bDriveOut};   7: return rCutOut;
      8: return gCutOut;             9: return bCutOut;
      10: return srcCtrl;            11: return lumaCtrl;
      12: return filtCtrl;           13: return {2'b0, hShiftOut};
      14: return {2'b0, vSlopeOut};  15: return {2'b0, vSizeOut};
      16: return {2'b0, sCorrOut};   17: return {2'b0, vShiftOut};
      default: return deflCtrl;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 19; i++) check(req, 32'(getOut(i)), 32'(model[i]));
  endtask

  task automatic busWait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic startBit();
    sdaDrv = 1'b1; busWait(); sclDrv = 1'b1; busWait();
    sdaDrv = 1'b0; busWait(); sclDrv = 1'b0; busWait();
  endtask

  task automatic stopBit();
    sdaDrv = 1'b0; busWait(); sclDrv = 1'b1; busWait(); sdaDrv = 1'b1; busWait();
  endtask

  task automatic sendBits(input logic [7:0] b, input int nb, input bit vbAlign);
    for (int i = 7; i >= 8 - nb; i--) begin
      sdaDrv = b[i]; busWait(); sclDrv = 1'b1; busWait(); busWait(); sclDrv = 1'b0;
      if (i == 0 && vbAlign) begin
        // write strobe lands on the 4th rising edge after the falling SCL
        repeat (3) @(posedge clk);
        @(negedge clk); vblankStb = 1'b1;
        @(negedge clk); vblankStb = 1'b0;
      end
      busWait();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit vbAlign, output logic ack);
    sendBits(b, 8, vbAlign);
    sdaDrv = 1'b1; busWait(); sclDrv = 1'b1; busWait();
    ack = ~sdaLine;
    busWait(); sclDrv = 1'b0; busWait();
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] b);
    b = '0; sdaDrv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      busWait(); sclDrv = 1'b1; busWait();
      b = {b[6:0], sdaLine};
      busWait(); sclDrv = 1'b0;
    end
    busWait(); sdaDrv = nack; busWait(); sclDrv = 1'b1; busWait(); busWait();
    sclDrv = 1'b0; busWait();
  endtask

  task automatic writeTx(input logic [7:0] dev, input logic [7:0] sub,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input int n, input bit vbFirst, output logic [4:0] acks);
    logic a;
    acks = '0;
    startBit();
    sendByte(dev, 1'b0, a); acks[0] = a;
    sendByte(sub, 1'b0, a); acks[1] = a;
    sendByte(d0, vbFirst, a); acks[2] = a;
    if (n > 1) begin sendByte(d1, 1'b0, a); acks[3] = a; end
    if (n > 2) begin sendByte(d2, 1'b0, a); acks[4] = a; end
    stopBit();
  endtask

  task automatic readTx(output logic ack, output logic [7:0] b);
    startBit();
    sendByte(8'hBB, 1'b0, ack);
    recvByte(1'b1, b);
    stopBit();
  endtask

  task automatic pulseVblank();
    @(negedge clk); vblankStb = 1'b1;
    @(negedge clk); vblankStb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [4:0] acks;
    logic       a;
    logic [7:0] rd;
    model = '{8'd71, 8'd58, 8'd64, 8'd72, 8'd16, 8'd30, 8'd30, 8'd128, 8'd128, 8'd128,
              8'd0, 8'd0, 8'd0, 8'd32, 8'd32, 8'd32, 8'd32, 8'd32, 8'd0};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values and released SDA
    checkAll("R1");
    check("R1 sdaOe", 32'(sdaOe), 32'd0);

    // R3/R4: single-mode writes walked from the vector table
    for (int v = 0; v < NVEC; v++) begin
      writeTx(8'hBA, VECS[v][23:16], VECS[v][15:8], 8'h00, 8'h00, 1, 1'b0, acks);
      check("R2 ack", 32'(acks[2:0]), 32'h7);
      model[VECS[v][20:16]] = VECS[v][7:0];
      check("R3/R4 value", 32'(getOut(int'(VECS[v][20:16]))), 32'(VECS[v][7:0]));
    end
    checkAll("R3 others");

    // R3: second byte in single mode is acked and dropped
    writeTx(8'hBA, 8'h08, 8'h11, 8'h22, 8'h00, 2, 1'b0, acks);
    check("R3 acks", 32'(acks[3:0]), 32'hF);
    model[8] = 8'h11;
    checkAll("R3 single");

    // R5: burst from 0x0D
    writeTx(8'hBA, 8'h2D, 8'h01, 8'h02, 8'h03, 3, 1'b0, acks);
    check("R5 acks", 32'(acks), 32'h1F);
    model[13] = 8'h01; model[14] = 8'h02; model[15] = 8'h03;
    checkAll("R5 burst");

    // R6: burst saturates at 0x12
    writeTx(8'hBA, 8'h31, 8'h05, 8'h06, 8'h07, 3, 1'b0, acks);
    model[17] = 8'h05; model[18] = 8'h07;
    checkAll("R6 saturate");

    // R7: out-of-range index acknowledged and dropped
    writeTx(8'hBA, 8'h15, 8'h33, 8'h00, 8'h00, 1, 1'b0, acks);
    check("R7 acks", 32'(acks[2:0]), 32'h7);
    checkAll("R7 unchanged");

    // R2: foreign address never acknowledged, nothing written
    writeTx(8'hB8, 8'h05, 8'h01, 8'h00, 8'h00, 1, 1'b0, acks);
    check("R2 nack", 32'(acks[2:0]), 32'h0);
    checkAll("R2 unchanged");

    // R8: shadow hold, then transfer on strobe
    writeTx(8'hBA, 8'h00, 8'h10, 8'h00, 8'h00, 1, 1'b0, acks);
    check("R8 held", 32'(brightOut), 32'd71);
    pulseVblank();
    check("R8 after strobe", 32'(brightOut), 32'h10);
    model[0] = 8'h10;

    // R8: write coinciding with the strobe waits for the next strobe
    writeTx(8'hBA, 8'h01, 8'h20, 8'h00, 8'h00, 1, 1'b1, acks);
    check("R8 coincide", 32'(contrastOut), 32'd58);
    pulseVblank();
    check("R8 next strobe", 32'(contrastOut), 32'h20);
    model[1] = 8'h20;

    // R8/R4: burst into shadow registers with masking
    writeTx(8'hBA, 8'h22, 8'h05, 8'hFF, 8'h00, 2, 1'b0, acks);
    check("R8 tint held", 32'(tintOut), 32'd64);
    pulseVblank();
    model[2] = 8'h05; model[3] = 8'h7F;
    checkAll("R8 burst");

    // R9: status byte layout and power-on flag clearing
    lockLost = 1'b1; field60 = 1'b0; stdIdent = 1'b1; stdSel = 3'b010;
    readTx(a, rd);
    check("R9 addr ack", 32'(a), 32'd1);
    check("R9 first read", 32'(rd), 32'hB2);
    lockLost = 1'b0; field60 = 1'b1; stdIdent = 1'b0; stdSel = 3'b001;
    readTx(a, rd);
    check("R9 second read", 32'(rd), 32'h41);

    // R10: stop in mid data byte drops it
    startBit();
    sendByte(8'hBA, 1'b0, a);
    sendByte(8'h05, 1'b0, a);
    sendBits(8'h11, 4, 1'b0);
    stopBit();
    checkAll("R10 stop abort");

    // R10: repeated start in mid byte, then a full transfer
    startBit();
    sendByte(8'hBA, 1'b0, a);
    sendByte(8'h06, 1'b0, a);
    sendBits(8'h2A, 3, 1'b0);
    startBit();
    sendByte(8'hBA, 1'b0, a);
    sendByte(8'h06, 1'b0, a);
    sendByte(8'h15, 1'b0, a);
    stopBit();
    model[6] = 8'h15;
    checkAll("R10 restart");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (WATCHDOG) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule